// File: doc/BRIEF.md
# Packed-Lane Variable Rounding Shifter

This block shifts every lane of a packed vector operand by a count taken from the same lane of a second operand. It is meant for the execution stage of a vector datapath. The count is a signed byte. A positive count shifts left and a negative count shifts right by its magnitude. Three mode inputs are decoded by every lane. One selects signed or unsigned lanes. One makes right shifts add back the last bit that was shifted out. One makes left shifts clamp on overflow instead of wrapping.

The lane results are captured in a register one cycle after a valid input. An output valid marks the captured result. A sticky saturation flag records that some lane clamped at some point since the last explicit clear. The lane width and the vector width are parameters, and the number of lanes is derived from them.

Top module: `simd_rshl_top`

## Requirements
- R1: The count for each lane is the low 8 bits of the matching lane of `opB`, read as two's complement. Positive values shift left. Negative values shift right by their magnitude, so 8'h80 means a right shift by 128.
- R2: A right shift is arithmetic when `isSigned`=1 and logical when `isSigned`=0. When the magnitude is at or above the lane width, a signed lane becomes copies of its sign bit and an unsigned lane becomes zero.
- R3: With `doSat`=0, a left shift drops the bits that move out of the lane. A left count at or above the lane width gives zero.
- R4: With `doRound`=1, a right shift by n adds input bit n-1 to the shifted value, modulo the lane width. For n equal to the lane width, that bit is the input's top bit. For n above the lane width, the added bit is the sign bit in signed mode and 0 in unsigned mode.
- R5: With `doSat`=1 and `isSigned`=0, a left shift that would lose a 1 bit returns all ones and reports saturation. This includes any count at or above the lane width applied to a nonzero input. A zero input gives zero. Right shifts never saturate.
- R6: With `doSat`=1 and `isSigned`=1, a left shift whose result does not fit the signed lane returns the lane maximum for a non-negative input and the lane minimum for a negative input, and reports saturation.
- R7: A zero count returns the lane unchanged in every mode combination and never saturates.
- R8: `satFlag` is set after any valid input in which at least one lane saturated. It stays set until a cycle with `satClear`=1. When a clear and a new saturation arrive in the same cycle, the flag ends up set.
- R9: `result` and `outValid` appear one cycle after the input. `outValid` copies `inValid`. `result` holds its value when `inValid` is low.
- R10: After reset, `result`, `outValid` and `satFlag` are all zero.
- R11: Each lane is computed only from its own operand lanes. Different counts and inputs in neighbouring lanes do not interact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and modes are valid this cycle |
| opA | input | VEC_W | Packed vector to be shifted |
| opB | input | VEC_W | Packed per-lane shift counts (low byte of each lane) |
| isSigned | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| doRound | input | 1 | 1 = right shifts round |
| doSat | input | 1 | 1 = left shifts saturate |
| satClear | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Registered result is valid |
| result | output | VEC_W | Registered shifted vector |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
Several rules are checked by assertions on every cycle. The checker follows the valid timing, holds the result on idle cycles, keeps the flag sticky and lets an idle clear empty it. On lane 0 it also checks that a zero count passes the lane through, that a non-saturating left shift past the lane width gives zero, and that an unsigned saturating shift of that size clamps to all ones. The bench scenarios cover the arithmetic the assertions cannot express compactly. These are the sign fill, the rounding bit at, below and beyond the lane width, the overflow limits of signed and unsigned clamping, lane independence, and a clear arriving in the same cycle as a new saturation.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;

  typedef struct packed {
    logic capture;
    logic satSet;
    logic satClr;
  } shiftStrobes_t;

endpackage

// File: rtl/simd_shift_lane.sv
module simd_shift_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] laneIn,
  input  logic [7:0]        cntIn,
  input  logic              isSigned,
  input  logic              doRound,
  input  logic              doSat,
  output logic [LANE_W-1:0] laneOut,
  output logic              laneSat
);
  localparam int WIDE_W = 2 * LANE_W;

  logic              isRight;
  logic [7:0]        mag;
  logic              bigCnt;
  logic              inRange;
  logic              signFill;
  logic [WIDE_W-1:0] extIn;
  logic [WIDE_W-1:0] wideLeft;
  logic [LANE_W-1:0] base;
  logic              rndBit;
  logic              ovf;
  logic [LANE_W-1:0] leftLow;
  logic [LANE_W:0]   hiSigned;
  logic [LANE_W-1:0] clampVal;

  always_comb begin
    isRight  = cntIn[7];
    mag      = isRight ? (~cntIn + 8'd1) : cntIn;
    bigCnt   = ({1'b0, mag} >= 9'(LANE_W));
    inRange  = ({1'b0, mag} <= 9'(LANE_W));
    signFill = isSigned & laneIn[LANE_W-1];
    extIn    = {{LANE_W{signFill}}, laneIn};
    wideLeft = extIn << mag;
    hiSigned = wideLeft[WIDE_W-1:LANE_W-1];
    clampVal = signFill ? {1'b1, {(LANE_W-1){1'b0}}}
                        : (isSigned ? {1'b0, {(LANE_W-1){1'b1}}} : {LANE_W{1'b1}});

    laneOut  = laneIn;
    laneSat  = 1'b0;
    base     = '0;
    rndBit   = 1'b0;
    ovf      = 1'b0;
    leftLow  = '0;

    if (mag == 8'd0) begin
      laneOut = laneIn;
    end else if (isRight) begin
      base = bigCnt ? {LANE_W{signFill}} : LANE_W'(extIn >> mag);
      if (inRange)
        rndBit = |(laneIn & (LANE_W'(1) << (mag - 8'd1)));
      else
        rndBit = signFill;
      laneOut = base + LANE_W'(doRound & rndBit);
    end else begin
      if (bigCnt) begin
        leftLow = '0;
        ovf     = (laneIn != '0);
      end else begin
        leftLow = wideLeft[LANE_W-1:0];
        if (isSigned)
          ovf = !((hiSigned == '0) || (hiSigned == '1));
        else
          ovf = (wideLeft[WIDE_W-1:LANE_W] != '0);
      end
      if (doSat && ovf) begin
        laneOut = clampVal;
        laneSat = 1'b1;
      end else begin
        laneOut = leftLow;
      end
    end
  end

endmodule

// File: rtl/simd_shift_datapath.sv
module simd_shift_datapath
  import simd_shift_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int VEC_W  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  input  logic               isSigned,
  input  logic               doRound,
  input  logic               doSat,
  input  shiftStrobes_t      strobes,
  output logic               anyLaneSat,
  output logic [VEC_W-1:0]   resultQ
);
  localparam int LANES = VEC_W / LANE_W;

  logic [VEC_W-1:0] laneRes;
  logic [LANES-1:0] laneSatVec;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    simd_shift_lane #(.LANE_W(LANE_W)) laneInst (
      .laneIn  (opA[ln*LANE_W +: LANE_W]),
      .cntIn   (opB[ln*LANE_W +: 8]),
      .isSigned(isSigned),
      .doRound (doRound),
      .doSat   (doSat),
      .laneOut (laneRes[ln*LANE_W +: LANE_W]),
      .laneSat (laneSatVec[ln])
    );
  end

  assign anyLaneSat = |laneSatVec;

  always_ff @(posedge clk) begin
    if (!rstN)
      resultQ <= '0;
    else if (strobes.capture)
      resultQ <= laneRes;
  end

endmodule

// File: rtl/simd_shift_ctrl.sv
module simd_shift_ctrl
  import simd_shift_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          satClear,
  input  logic          anyLaneSat,
  output shiftStrobes_t strobes,
  output logic          outValid,
  output logic          satFlag
);
  always_comb begin
    strobes.capture = inValid;
    strobes.satSet  = inValid & anyLaneSat;
    strobes.satClr  = satClear;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      outValid <= inValid;
      satFlag  <= (satFlag & ~strobes.satClr) | strobes.satSet;
    end
  end

endmodule

// File: rtl/simd_rshl_top.sv
module simd_rshl_top
  import simd_shift_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int VEC_W  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic             isSigned,
  input  logic             doRound,
  input  logic             doSat,
  input  logic             satClear,
  output logic             outValid,
  output logic [VEC_W-1:0] result,
  output logic             satFlag
);
  shiftStrobes_t strobes;
  logic          anyLaneSat;

  simd_shift_ctrl ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .satClear  (satClear),
    .anyLaneSat(anyLaneSat),
    .strobes   (strobes),
    .outValid  (outValid),
    .satFlag   (satFlag)
  );

  simd_shift_datapath #(.LANE_W(LANE_W), .VEC_W(VEC_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .isSigned  (isSigned),
    .doRound   (doRound),
    .doSat     (doSat),
    .strobes   (strobes),
    .anyLaneSat(anyLaneSat),
    .resultQ   (result)
  );

endmodule

// File: rtl/simd_rshl_chk.sv
module simd_rshl_chk #(
  parameter int LANE_W = 8,
  parameter int VEC_W  = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] opA,
  input logic [VEC_W-1:0] opB,
  input logic             isSigned,
  input logic             doSat,
  input logic             satClear,
  input logic             outValid,
  input logic [VEC_W-1:0] result,
  input logic             satFlag
);
  logic bigLeft0;
  assign bigLeft0 = !opB[7] && (opB[7:0] >= 8'(LANE_W));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !satClear) |=> satFlag);
  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (satClear && !inValid) |=> !satFlag);
  assert_zero_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opB[7:0] == 8'd0) |=> result[LANE_W-1:0] == $past(opA[LANE_W-1:0]));
  assert_wide_left_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !doSat && bigLeft0) |=> result[LANE_W-1:0] == '0);
  assert_unsigned_clamp_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && doSat && !isSigned && bigLeft0 && opA[LANE_W-1:0] != '0)
      |=> (result[LANE_W-1:0] == '1) && satFlag);

endmodule

bind simd_rshl_top simd_rshl_chk #(.LANE_W(LANE_W), .VEC_W(VEC_W)) chkInst (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opA     (opA),
  .opB     (opB),
  .isSigned(isSigned),
  .doSat   (doSat),
  .satClear(satClear),
  .outValid(outValid),
  .result  (result),
  .satFlag (satFlag)
);

// File: tb/tb_simd_rshl_top.sv
`timescale 1ns/1ps
module tb_simd_rshl_top;
  localparam int LANE_W = 8;
  localparam int VEC_W  = 64;
  localparam int LANES  = VEC_W / LANE_W;

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] a;
    logic [7:0] cnt;
    logic [2:0] mode;   // {isSigned, doRound, doSat}
    logic [7:0] expVal;
    logic       expSat;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{4'd7,  8'h5A, 8'h00, 3'b111, 8'h5A, 1'b0}, // R7
    '{4'd7,  8'h5A, 8'h00, 3'b000, 8'h5A, 1'b0}, // R7
    '{4'd1,  8'h13, 8'h02, 3'b000, 8'h4C, 1'b0}, // R1
    '{4'd3,  8'h93, 8'h03, 3'b000, 8'h98, 1'b0}, // R3
    '{4'd3,  8'hFF, 8'h08, 3'b000, 8'h00, 1'b0}, // R3
    '{4'd3,  8'hFF, 8'h64, 3'b100, 8'h00, 1'b0}, // R3
    '{4'd2,  8'h90, 8'hFE, 3'b100, 8'hE4, 1'b0}, // R2
    '{4'd2,  8'h90, 8'hFE, 3'b000, 8'h24, 1'b0}, // R2
    '{4'd2,  8'h90, 8'hF8, 3'b100, 8'hFF, 1'b0}, // R2
    '{4'd2,  8'h90, 8'hF7, 3'b000, 8'h00, 1'b0}, // R2
    '{4'd1,  8'h70, 8'h80, 3'b100, 8'h00, 1'b0}, // R1 count -128
    '{4'd4,  8'h17, 8'hFE, 3'b010, 8'h06, 1'b0}, // R4
    '{4'd4,  8'h15, 8'hFE, 3'b010, 8'h05, 1'b0}, // R4
    '{4'd4,  8'hF9, 8'hFF, 3'b110, 8'hFD, 1'b0}, // R4
    '{4'd4,  8'h80, 8'hF8, 3'b010, 8'h01, 1'b0}, // R4
    '{4'd4,  8'h80, 8'hF8, 3'b110, 8'h00, 1'b0}, // R4
    '{4'd4,  8'h80, 8'hF7, 3'b110, 8'h00, 1'b0}, // R4
    '{4'd4,  8'h80, 8'hF7, 3'b010, 8'h00, 1'b0}, // R4
    '{4'd4,  8'h7F, 8'hF7, 3'b110, 8'h00, 1'b0}, // R4
    '{4'd5,  8'h01, 8'h08, 3'b001, 8'hFF, 1'b1}, // R5
    '{4'd5,  8'h00, 8'h09, 3'b001, 8'h00, 1'b0}, // R5
    '{4'd5,  8'h21, 8'h03, 3'b001, 8'hFF, 1'b1}, // R5
    '{4'd5,  8'h1F, 8'h03, 3'b001, 8'hF8, 1'b0}, // R5
    '{4'd5,  8'hFF, 8'hFC, 3'b001, 8'h0F, 1'b0}, // R5
    '{4'd6,  8'h21, 8'h02, 3'b101, 8'h7F, 1'b1}, // R6
    '{4'd6,  8'hE0, 8'h02, 3'b101, 8'h80, 1'b0}, // R6
    '{4'd6,  8'hDF, 8'h02, 3'b101, 8'h80, 1'b1}, // R6
    '{4'd6,  8'h90, 8'h08, 3'b101, 8'h80, 1'b1}, // R6
    '{4'd6,  8'h10, 8'h03, 3'b101, 8'h7F, 1'b1}  // R6
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [VEC_W-1:0] opA = '0;
  logic [VEC_W-1:0] opB = '0;
  logic             isSigned = 1'b0;
  logic             doRound = 1'b0;
  logic             doSat = 1'b0;
  logic             satClear = 1'b0;
  logic             outValid;
  logic [VEC_W-1:0] result;
  logic             satFlag;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  simd_rshl_top #(.LANE_W(LANE_W), .VEC_W(VEC_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .isSigned(isSigned), .doRound(doRound), .doSat(doSat), .satClear(satClear),
    .outValid(outValid), .result(result), .satFlag(satFlag)
  );

  task automatic check(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b,
                       input logic [2:0] mode, input logic clr);
    @(negedge clk);
    opA = a; opB = b;
    {isSigned, doRound, doSat} = mode;
    satClear = clr;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    satClear = 1'b0;
  endtask

  task automatic finishRun;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 result", result, '0);
    check("R10 outValid", VEC_W'(outValid), '0);
    check("R10 satFlag", VEC_W'(satFlag), '0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive({LANES{VECS[i].a}}, {LANES{VECS[i].cnt}}, VECS[i].mode, 1'b1);
      check($sformatf("R%0d vector %0d result", VECS[i].req, i), result, {LANES{VECS[i].expVal}});
      check($sformatf("R%0d vector %0d flag", VECS[i].req, i), VEC_W'(satFlag), VEC_W'(VECS[i].expSat));
    end

    // R9: valid timing and hold
    drive(64'h0000_0000_0000_0013, 64'h0, 3'b000, 1'b1);
    check("R9 outValid after input", VEC_W'(outValid), 1);
    @(negedge clk);
    check("R9 outValid idle", VEC_W'(outValid), 0);
    check("R9 result held", result, 64'h0000_0000_0000_0013);

    // R11: independent lanes, counts differ per lane
    drive(64'h0000_0000_0000_8001, 64'h0000_0000_0000_F901, 3'b000, 1'b1);
    check("R11 mixed lanes", result, 64'h0000_0000_0000_0102);

    // R8: one saturating lane sets the flag; it sticks
    drive(64'h0000_0000_0000_0121, 64'h0000_0000_0000_0103, 3'b001, 1'b1);
    check("R11 sat lane beside normal lane", result, 64'h0000_0000_0000_02FF);
    check("R8 flag set by one lane", VEC_W'(satFlag), 1);
    repeat (3) @(negedge clk);
    drive(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 3'b001, 1'b0);
    check("R8 flag sticky", VEC_W'(satFlag), 1);
    @(negedge clk);
    satClear = 1'b1;
    @(negedge clk);
    satClear = 1'b0;
    check("R8 flag cleared", VEC_W'(satFlag), 0);
    drive({LANES{8'h01}}, {LANES{8'h08}}, 3'b001, 1'b1);
    check("R8 set wins over clear", VEC_W'(satFlag), 1);

    finishRun();
  end

endmodule